// File: doc/BRIEF.md
# USB PHY enable sequencer

This block runs the bring-up or shut-down of one USB PHY port as a fixed ordered walk of steps. A request carries the direction (on or off), the port number, a three-bit variant class and two presence flags: one for the port-side register block and one for a supply regulator. The sequencer then emits, in this order:

- register updates as set and clear masks, each applied as `new = (old & ~clr) | set`;
- tuning writes to an external bit-serial PHY writer, waiting for that writer to finish each one;
- a switch command for the port's VBUS supply;
- a single-cycle completion pulse.

Which steps run, and the tuning values, depend on the variant class, on whether the port is port 0, and on the external VBUS sense input. Only host operation is supported, so the ID and VBUS override fields are always forced to host values.

The class codes are:

| Code | Tuning writes | Disconnect threshold | Port 0 reroute | Auxiliary clear |
|------|---------------|----------------------|----------------|-----------------|
| 0 | yes | 2 | no | no |
| 1 | yes | 3 | no | no |
| 2 | yes | 3 | yes | yes |
| 3 | no | — | yes | no |
| 4 | no | — | no | no |
| 5 to 7 | no | — | no | no |

Bit-serial writes carry a start bit address, a value and a length. The writer shifts the value out least significant bit first.

Top module: `usbphy_bringup_seq`

## Requirements
- R1: After reset, and after a reset in the middle of a sequence, every strobe, mask and value output is 0 and nothing is emitted until the next start.
- R2: When port registers are present, the first step writes target code 0 (port configuration), with mask 0x701 (bits 0, 8, 9 and 10) in `cfg_set_o` on enable, or in `cfg_clr_o` on disable. When they are absent, the step emits nothing.
- R3: On enable with class 2 and port registers present, a write to target code 1 (port auxiliary) clears mask 0x2 (bit 1) and sets nothing. It is not emitted on disable.
- R4: Tuning writes occur only on enable, and only for class codes 0, 1 and 2. On port 0 they begin with a 1-bit write of value 1 at bit address 0x0C.
- R5: Every tuned port writes 5 bits of value 0x14 at address 0x20, then 2 bits of the disconnect threshold at address 0x2A. The threshold is 2 for class 0 and 3 for classes 1 and 2.
- R6: Each tuning request is a one-cycle pulse of `bw_req_o`. No further output activity occurs until `bw_done_i` is seen, however long the writer takes.
- R7: Only for port 0, target code 2 (shared control) is written with clear mask 0xF000 and set mask 0xB000, which forces ID to 2 and VBUS to 3. On enable, bits 17 and 16 (0x30000) are added to the set mask; on disable, they are added to the clear mask.
- R8: For port 0 with class 2 or 3, a write to target code 3 (shared routing) clears mask 0x1. This happens on both enable and disable.
- R9: With a regulator present, disable issues `supply_wr_o` with `supply_on_o` = 0. Enable issues it with `supply_on_o` = 1, except on port 0 when VBUS is sensed or no sense input exists. Without a regulator, no supply command is issued.
- R10: Steps appear in the order: configuration, auxiliary, tuning, shared control, routing, supply. At most one output strobe is active per cycle. `done_o` pulses for exactly one cycle, once, after the last step.
- R11: A start pulse that arrives while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sequence (accepted when idle) |
| on_i | input | 1 | 1 = bring up, 0 = shut down |
| port_i | input | PORT_W | Port number |
| class_i | input | 3 | Variant class code |
| port_regs_i | input | 1 | Port-side register block exists |
| supply_present_i | input | 1 | Port has a switchable supply regulator |
| vbus_sense_present_i | input | 1 | A VBUS sense input exists |
| vbus_sense_i | input | 1 | External VBUS detected |
| bw_req_o | output | 1 | Bit-serial write request pulse |
| bw_addr_o | output | BW_ADDR_W | Start bit address |
| bw_bits_o | output | BW_DATA_W | Value, LSB sent first |
| bw_len_o | output | BW_LEN_W | Number of bits |
| bw_done_i | input | 1 | Writer finished the current write |
| cfg_wr_o | output | 1 | Register update strobe |
| cfg_tgt_o | output | 2 | Target register code |
| cfg_port_o | output | PORT_W | Port the update belongs to |
| cfg_set_o | output | REG_W | Bits to set |
| cfg_clr_o | output | REG_W | Bits to clear |
| supply_wr_o | output | 1 | Supply command strobe |
| supply_on_o | output | 1 | Supply command value |
| done_o | output | 1 | Sequence complete pulse |

## Verification
The bench goes after the port-0 VBUS exception. A design that ignored a missing sense input, or applied the exception to other ports or to disable, would issue a wrong supply command or omit one. It also covers the classes that skip tuning and the unassigned codes; a wrong class decode shows up as extra or missing serial writes or a wrong threshold. A slow writer and a second start pulse mid-sequence expose a sequencer that runs ahead of `bw_done_i` or restarts while busy. A reset in the middle of a sequence catches a design that leaves stale strobes active.

// File: rtl/usbphy_seq_pkg.sv
package usbphy_seq_pkg;

    localparam int CLS_W = 3;

    localparam logic [CLS_W-1:0] VC_TUNE_T2    = 3'd0;
    localparam logic [CLS_W-1:0] VC_TUNE_T3    = 3'd1;
    localparam logic [CLS_W-1:0] VC_TUNE_ROUTE = 3'd2;
    localparam logic [CLS_W-1:0] VC_ROUTE_ONLY = 3'd3;
    localparam logic [CLS_W-1:0] VC_BARE       = 3'd4;

    typedef enum logic [1:0] {
        TGT_PORT_CFG = 2'd0,
        TGT_PORT_AUX = 2'd1,
        TGT_SH_CTRL  = 2'd2,
        TGT_SH_ROUTE = 2'd3
    } tgt_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CFG, ST_AUX, ST_CAL, ST_AMP, ST_DISC,
        ST_WAIT, ST_CTRL, ST_ROUTE, ST_SUP, ST_DONE
    } step_e;

    typedef struct packed {
        logic       tune;
        logic       route;
        logic       aux_clr;
        logic [1:0] thresh;
    } cls_cfg_t;

    // port configuration bits
    localparam int CFG_BYPASS_BIT = 0;
    localparam int CFG_ALIGN_BIT  = 8;
    localparam int CFG_INCR4_BIT  = 9;
    localparam int CFG_INCR8_BIT  = 10;
    // port auxiliary bit
    localparam int AUX_CLR_BIT    = 1;
    // shared control fields
    localparam int CTRL_IDPU_BIT  = 17;
    localparam int CTRL_LNPU_BIT  = 16;
    localparam int CTRL_IDF_LSB   = 14;
    localparam int CTRL_VBF_LSB   = 12;
    localparam int IDF_FORCE_LOW  = 2;
    localparam int VBF_FORCE_HIGH = 3;
    // shared routing bit
    localparam int ROUTE_BIT      = 0;

    // bit-serial tuning targets
    localparam int SER_CAL_ADDR  = 'h0C;
    localparam int SER_AMP_ADDR  = 'h20;
    localparam int SER_DISC_ADDR = 'h2A;
    localparam int SER_AMP_VAL   = 'h14;
    localparam int SER_AMP_LEN   = 5;
    localparam int SER_DISC_LEN  = 2;

endpackage

// File: rtl/usbphy_class_decode.sv
module usbphy_class_decode
    import usbphy_seq_pkg::*;
(
    input  logic [CLS_W-1:0] cls_i,
    output cls_cfg_t         cfg_o
);
    always_comb begin
        cfg_o = '0;
        case (cls_i)
            VC_TUNE_T2: begin
                cfg_o.tune   = 1'b1;
                cfg_o.thresh = 2'd2;
            end
            VC_TUNE_T3: begin
                cfg_o.tune   = 1'b1;
                cfg_o.thresh = 2'd3;
            end
            VC_TUNE_ROUTE: begin
                cfg_o.tune    = 1'b1;
                cfg_o.route   = 1'b1;
                cfg_o.aux_clr = 1'b1;
                cfg_o.thresh  = 2'd3;
            end
            VC_ROUTE_ONLY: begin
                cfg_o.route  = 1'b1;
                cfg_o.thresh = 2'd3;
            end
            VC_BARE: cfg_o.thresh = 2'd0;
            default: cfg_o = '0;
        endcase
    end
endmodule

// File: rtl/usbphy_mask_gen.sv
module usbphy_mask_gen
    import usbphy_seq_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  step_e            step_i,
    input  logic             on_i,
    output tgt_e             tgt_o,
    output logic [REG_W-1:0] set_o,
    output logic [REG_W-1:0] clr_o
);
    localparam logic [REG_W-1:0] ONE = REG_W'(1);
    localparam logic [REG_W-1:0] CFG_MASK =
        (ONE << CFG_BYPASS_BIT) | (ONE << CFG_ALIGN_BIT) |
        (ONE << CFG_INCR4_BIT)  | (ONE << CFG_INCR8_BIT);
    localparam logic [REG_W-1:0] PU_MASK  =
        (ONE << CTRL_IDPU_BIT) | (ONE << CTRL_LNPU_BIT);
    localparam logic [REG_W-1:0] FLD_MASK =
        (REG_W'(3) << CTRL_IDF_LSB) | (REG_W'(3) << CTRL_VBF_LSB);
    localparam logic [REG_W-1:0] FLD_VAL  =
        (REG_W'(IDF_FORCE_LOW) << CTRL_IDF_LSB) |
        (REG_W'(VBF_FORCE_HIGH) << CTRL_VBF_LSB);

    always_comb begin
        tgt_o = TGT_PORT_CFG;
        set_o = '0;
        clr_o = '0;
        case (step_i)
            ST_CFG: begin
                tgt_o = TGT_PORT_CFG;
                if (on_i) set_o = CFG_MASK;
                else      clr_o = CFG_MASK;
            end
            ST_AUX: begin
                tgt_o = TGT_PORT_AUX;
                clr_o = ONE << AUX_CLR_BIT;
            end
            ST_CTRL: begin
                tgt_o = TGT_SH_CTRL;
                set_o = FLD_VAL  | (on_i ? PU_MASK : '0);
                clr_o = FLD_MASK | (on_i ? '0 : PU_MASK);
            end
            ST_ROUTE: begin
                tgt_o = TGT_SH_ROUTE;
                clr_o = ONE << ROUTE_BIT;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/usbphy_bringup_seq.sv
module usbphy_bringup_seq
    import usbphy_seq_pkg::*;
#(
    parameter int PORTS     = 4,
    parameter int REG_W     = 32,
    parameter int BW_ADDR_W = 8,
    parameter int BW_DATA_W = 8,
    parameter int BW_LEN_W  = 3,
    localparam int PORT_W   = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 on_i,
    input  logic [PORT_W-1:0]    port_i,
    input  logic [2:0]           class_i,
    input  logic                 port_regs_i,
    input  logic                 supply_present_i,
    input  logic                 vbus_sense_present_i,
    input  logic                 vbus_sense_i,
    output logic                 bw_req_o,
    output logic [BW_ADDR_W-1:0] bw_addr_o,
    output logic [BW_DATA_W-1:0] bw_bits_o,
    output logic [BW_LEN_W-1:0]  bw_len_o,
    input  logic                 bw_done_i,
    output logic                 cfg_wr_o,
    output logic [1:0]           cfg_tgt_o,
    output logic [PORT_W-1:0]    cfg_port_o,
    output logic [REG_W-1:0]     cfg_set_o,
    output logic [REG_W-1:0]     cfg_clr_o,
    output logic                 supply_wr_o,
    output logic                 supply_on_o,
    output logic                 done_o
);
    typedef struct packed {
        step_e             st;
        step_e             ret;
        logic              on;
        logic [PORT_W-1:0] port;
        logic [CLS_W-1:0]  cls;
        logic              has_pr;
        logic              has_sup;
    } seq_t;

    seq_t seq_d, seq_q;

    cls_cfg_t         ccfg;
    tgt_e             mg_tgt;
    logic [REG_W-1:0] mg_set, mg_clr;
    logic             port0;
    logic             vbus_seen;

    usbphy_class_decode u_cls (
        .cls_i (seq_q.cls),
        .cfg_o (ccfg)
    );

    usbphy_mask_gen #(.REG_W(REG_W)) u_mask (
        .step_i (seq_q.st),
        .on_i   (seq_q.on),
        .tgt_o  (mg_tgt),
        .set_o  (mg_set),
        .clr_o  (mg_clr)
    );

    assign port0     = (seq_q.port == '0);
    assign vbus_seen = vbus_sense_i || !vbus_sense_present_i;

    always_comb begin
        seq_d       = seq_q;
        bw_req_o    = 1'b0;
        bw_addr_o   = '0;
        bw_bits_o   = '0;
        bw_len_o    = '0;
        cfg_wr_o    = 1'b0;
        supply_wr_o = 1'b0;
        supply_on_o = 1'b0;
        done_o      = 1'b0;

        case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.on      = on_i;
                    seq_d.port    = port_i;
                    seq_d.cls     = class_i;
                    seq_d.has_pr  = port_regs_i;
                    seq_d.has_sup = supply_present_i;
                    seq_d.st      = ST_CFG;
                end
            end
            ST_CFG: begin
                cfg_wr_o = seq_q.has_pr;
                seq_d.st = ST_AUX;
            end
            ST_AUX: begin
                cfg_wr_o = seq_q.on && seq_q.has_pr && ccfg.aux_clr;
                seq_d.st = ST_CAL;
            end
            ST_CAL: begin
                if (seq_q.on && ccfg.tune && port0) begin
                    bw_req_o  = 1'b1;
                    bw_addr_o = BW_ADDR_W'(SER_CAL_ADDR);
                    bw_bits_o = BW_DATA_W'(1);
                    bw_len_o  = BW_LEN_W'(1);
                    seq_d.st  = ST_WAIT;
                    seq_d.ret = ST_AMP;
                end else begin
                    seq_d.st = ST_AMP;
                end
            end
            ST_AMP: begin
                if (seq_q.on && ccfg.tune) begin
                    bw_req_o  = 1'b1;
                    bw_addr_o = BW_ADDR_W'(SER_AMP_ADDR);
                    bw_bits_o = BW_DATA_W'(SER_AMP_VAL);
                    bw_len_o  = BW_LEN_W'(SER_AMP_LEN);
                    seq_d.st  = ST_WAIT;
                    seq_d.ret = ST_DISC;
                end else begin
                    seq_d.st = ST_CTRL;
                end
            end
            ST_DISC: begin
                bw_req_o  = 1'b1;
                bw_addr_o = BW_ADDR_W'(SER_DISC_ADDR);
                bw_bits_o = BW_DATA_W'(ccfg.thresh);
                bw_len_o  = BW_LEN_W'(SER_DISC_LEN);
                seq_d.st  = ST_WAIT;
                seq_d.ret = ST_CTRL;
            end
            ST_WAIT: begin
                if (bw_done_i) seq_d.st = seq_q.ret;
            end
            ST_CTRL: begin
                cfg_wr_o = port0;
                seq_d.st = ST_ROUTE;
            end
            ST_ROUTE: begin
                cfg_wr_o = port0 && ccfg.route;
                seq_d.st = ST_SUP;
            end
            ST_SUP: begin
                if (seq_q.has_sup && !(seq_q.on && port0 && vbus_seen)) begin
                    supply_wr_o = 1'b1;
                    supply_on_o = seq_q.on;
                end
                seq_d.st = ST_DONE;
            end
            ST_DONE: begin
                done_o   = 1'b1;
                seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase

        cfg_tgt_o  = cfg_wr_o ? mg_tgt     : '0;
        cfg_port_o = cfg_wr_o ? seq_q.port : '0;
        cfg_set_o  = cfg_wr_o ? mg_set     : '0;
        cfg_clr_o  = cfg_wr_o ? mg_clr     : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    // R6: a request lasts one cycle, then the sequencer holds still until the writer answers
    p_bw_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bw_req_o |=> !bw_req_o);
    p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_WAIT && !bw_done_i) |=>
            !(bw_req_o || cfg_wr_o || supply_wr_o || done_o));
    // R4: tuning traffic only during bring-up
    p_tune_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bw_req_o |-> seq_q.on);
    // R10: one strobe at a time, done is a lone pulse followed by idle
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bw_req_o, cfg_wr_o, supply_wr_o, done_o}));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && seq_q.st == ST_IDLE));
    // R2: port configuration touches exactly the four bits, never both ways
    p_cfg_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_o && cfg_tgt_o == TGT_PORT_CFG) |->
            ($countones(cfg_set_o | cfg_clr_o) == 4 && (cfg_set_o & cfg_clr_o) == '0));
    // R7: shared control only on behalf of port 0
    p_ctrl_port0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_o && cfg_tgt_o == TGT_SH_CTRL) |-> cfg_port_o == '0);
    // R9: supply never switched on for port 0 while VBUS is seen
    p_supply_vbus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_wr_o && supply_on_o) |->
            !(seq_q.port == '0 && (vbus_sense_i || !vbus_sense_present_i)));
endmodule

// File: tb/usbphy_bringup_seq_test.sv
`timescale 1ns/1ps
module usbphy_bringup_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, on_i = 1'b0;
    logic [1:0]  port_i = '0;
    logic [2:0]  class_i = '0;
    logic        port_regs_i = 1'b0, supply_present_i = 1'b0;
    logic        vbus_sense_present_i = 1'b0, vbus_sense_i = 1'b0;
    logic        bw_req_o, bw_done_i = 1'b0;
    logic [7:0]  bw_addr_o, bw_bits_o;
    logic [2:0]  bw_len_o;
    logic        cfg_wr_o;
    logic [1:0]  cfg_tgt_o, cfg_port_o;
    logic [31:0] cfg_set_o, cfg_clr_o;
    logic        supply_wr_o, supply_on_o, done_o;

    always #2.5 clk = ~clk;

    usbphy_bringup_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .on_i(on_i),
        .port_i(port_i), .class_i(class_i), .port_regs_i(port_regs_i),
        .supply_present_i(supply_present_i),
        .vbus_sense_present_i(vbus_sense_present_i), .vbus_sense_i(vbus_sense_i),
        .bw_req_o(bw_req_o), .bw_addr_o(bw_addr_o), .bw_bits_o(bw_bits_o),
        .bw_len_o(bw_len_o), .bw_done_i(bw_done_i),
        .cfg_wr_o(cfg_wr_o), .cfg_tgt_o(cfg_tgt_o), .cfg_port_o(cfg_port_o),
        .cfg_set_o(cfg_set_o), .cfg_clr_o(cfg_clr_o),
        .supply_wr_o(supply_wr_o), .supply_on_o(supply_on_o), .done_o(done_o)
    );

    int n_cmp = 0, n_bad = 0;
    int wr_delay = 2;
    int done_cnt = 0;

    logic [1:0]  gk [32];
    logic [31:0] g0 [32], g1 [32], g2 [32];
    int          gn = 0;
    logic [1:0]  ek [32];
    logic [31:0] e0 [32], e1 [32], e2 [32];
    int          en = 0;

    // {on, port[1:0], class[2:0], port_regs, supply, sense_present, sense, expected event count[3:0]}
    localparam int NV = 13;
    localparam logic [13:0] VEC [NV] = '{
        14'b1_00_000_1_1_0_0_0101,
        14'b1_00_010_1_1_1_0_1000,
        14'b1_01_001_1_1_1_1_0100,
        14'b1_10_011_1_0_1_0_0001,
        14'b1_00_100_0_1_1_1_0001,
        14'b0_00_010_1_1_1_0_0100,
        14'b0_11_000_1_1_0_0_0010,
        14'b1_00_011_1_1_1_0_0100,
        14'b1_11_010_0_0_0_0_0010,
        14'b1_01_100_1_1_0_0_0010,
        14'b1_00_001_1_1_1_1_0101,
        14'b0_10_100_0_0_0_0_0000,
        14'b1_01_101_1_0_0_0_0001
    };

    task automatic check(input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push_exp(input logic [1:0] k, input logic [31:0] a,
                            input logic [31:0] b, input logic [31:0] c);
        ek[en] = k; e0[en] = a; e1[en] = b; e2[en] = c;
        if (en < 31) en++;
    endtask

    // bit-serial writer model: answers wr_delay cycles after a request
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (bw_done_i) bw_done_i = 1'b0;
            if (bw_req_o) cnt = wr_delay;
            else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) bw_done_i = 1'b1;
            end
        end
    end

    // event recorder
    initial begin
        forever begin
            @(negedge clk);
            if (cfg_wr_o && gn < 32) begin
                gk[gn] = 2'd0; g0[gn] = 32'(cfg_tgt_o) * 16 + 32'(cfg_port_o);
                g1[gn] = cfg_set_o; g2[gn] = cfg_clr_o; gn++;
            end
            if (bw_req_o && gn < 32) begin
                gk[gn] = 2'd1; g0[gn] = 32'(bw_addr_o);
                g1[gn] = 32'(bw_bits_o); g2[gn] = 32'(bw_len_o); gn++;
            end
            if (supply_wr_o && gn < 32) begin
                gk[gn] = 2'd2; g0[gn] = 32'(supply_on_o); g1[gn] = 0; g2[gn] = 0; gn++;
            end
            if (done_o) done_cnt++;
        end
    end

    function automatic string tag_of(input int k);
        if (ek[k] == 2'd1) return (e0[k] == 32'h0C) ? "R4" : "R5";
        if (ek[k] == 2'd2) return "R9";
        case (e0[k][5:4])
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R7";
            default: return "R8";
        endcase
    endfunction

    // expected events derived from the requirements
    task automatic build_exp(input logic on, input logic [1:0] port, input logic [2:0] cls,
                             input logic pr, input logic sup, input logic vp, input logic vd);
        logic tune, route, aux;
        int thr;
        en    = 0;
        tune  = (cls <= 3'd2);
        route = (cls == 3'd2) || (cls == 3'd3);
        aux   = (cls == 3'd2);
        thr   = (cls == 3'd0) ? 2 : 3;
        if (pr) push_exp(2'd0, 32'(port), on ? 32'h701 : 0, on ? 0 : 32'h701);
        if (on && pr && aux) push_exp(2'd0, 32'h10 + 32'(port), 0, 32'h2);
        if (on && tune) begin
            if (port == 0) push_exp(2'd1, 32'h0C, 1, 1);
            push_exp(2'd1, 32'h20, 32'h14, 5);
            push_exp(2'd1, 32'h2A, thr, 2);
        end
        if (port == 0)
            push_exp(2'd0, 32'h20, 32'hB000 | (on ? 32'h30000 : 0),
                     32'hF000 | (on ? 0 : 32'h30000));
        if (port == 0 && route) push_exp(2'd0, 32'h30, 0, 32'h1);
        if (sup && !(on && port == 0 && (vd || !vp))) push_exp(2'd2, 32'(on), 0, 0);
    endtask

    task automatic run_case(input logic on, input logic [1:0] port, input logic [2:0] cls,
                            input logic pr, input logic sup, input logic vp, input logic vd,
                            input int exp_cnt, input logic poke_busy, input string name);
        int guard;
        build_exp(on, port, cls, pr, sup, vp, vd);
        @(negedge clk);
        gn = 0; done_cnt = 0;
        on_i = on; port_i = port; class_i = cls; port_regs_i = pr;
        supply_present_i = sup; vbus_sense_present_i = vp; vbus_sense_i = vd;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke_busy) begin
            @(negedge clk);
            on_i = ~on; port_i = 2'd0; start_i = 1'b1;   // R11: must be ignored
            @(negedge clk);
            start_i = 1'b0;
        end
        guard = 0;
        while (done_cnt == 0 && guard < 500) begin @(posedge clk); guard++; end
        repeat (4) @(posedge clk);
        check("R10", {name, " done pulses"}, 128'(done_cnt), 128'(1));
        check(poke_busy ? "R11" : "R6/R10", {name, " event count"}, 128'(gn), 128'(exp_cnt));
        for (int k = 0; k < en && k < gn; k++)
            check(tag_of(k), $sformatf("%s event %0d", name, k),
                  {30'd0, gk[k], g0[k], g1[k], g2[k]}, {30'd0, ek[k], e0[k], e1[k], e2[k]});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check("R1", "strobes in reset", {bw_req_o, cfg_wr_o, supply_wr_o, supply_on_o, done_o}, 0);
        check("R1", "masks in reset", {cfg_set_o, cfg_clr_o, bw_addr_o, bw_bits_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "idle without start", {bw_req_o, cfg_wr_o, supply_wr_o, done_o}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [13:0] v;
            v = VEC[i];
            run_case(v[13], v[12:11], v[10:8], v[7], v[6], v[5], v[4], int'(v[3:0]),
                     1'b0, $sformatf("vec%0d", i));
        end

        // R6: slow writer, same result
        wr_delay = 9;
        run_case(1'b1, 2'd0, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 8, 1'b0, "r6_slow_writer");
        wr_delay = 2;

        // R11: second start during a running sequence
        run_case(1'b1, 2'd1, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 4, 1'b1, "r11_busy_start");

        // R1: reset in mid-sequence
        @(negedge clk);
        gn = 0;
        on_i = 1'b1; port_i = 2'd0; class_i = 3'd0; port_regs_i = 1'b1;
        supply_present_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", "strobes after mid reset",
              {bw_req_o, cfg_wr_o, supply_wr_o, supply_on_o, done_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        gn = 0; done_cnt = 0;
        repeat (20) @(posedge clk);
        check("R1", "no events after mid reset", 128'(gn + done_cnt), 128'(0));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R10 watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule